// File: doc/BRIEF.md
# 1-Wire ROM Search Triplet Engine

This block runs one branch step of a 1-Wire ROM search as a single command. After a start, it reads the address bit that all slaves drive together, then reads the complement of that bit. From the two values it decides which branch of the address tree to follow, writes that direction bit back to the bus, and returns a 3-bit code. A search controller above the block issues one command for each of the 64 address positions. It supplies the direction it prefers, and it tracks discrepancies from the returned codes.

Bus timing is not handled here. Every single-bit access goes to a bit-level bus port as a one-cycle request strobe. The port answers with a one-cycle acknowledge, which carries the sampled bit on a read. Each access waits for its own acknowledge. If an acknowledge does not arrive within a parameterised number of cycles, the command is aborted and an error flag is raised.

Top module: `owsrch_triplet`

## Requirements
- R1: Each command makes its bus accesses in this fixed order: a read of the address bit, then a read of the complement bit, then (when one is due) a write of the chosen direction.
- R2: If both reads return 1, the result is 3'b011, no write is issued, and the command ends after exactly two accesses.
- R3: If both reads return 0, the direction sampled on `dir_req_i` at start is written, and the result is 3'b100 for direction 1 or 3'b000 for direction 0.
- R4: If exactly one read returns 1, the direction is forced to the address bit's value and that value is written. The result is 3'b101 when the address bit is 1 and 3'b010 when it is 0.
- R5: The result encoding is: bit 0 holds the address bit, bit 1 holds the complement bit, and bit 2 holds the direction taken.
- R6: `bit_req_o` is a one-cycle strobe. No new strobe is issued until the previous access has been acknowledged. An acknowledge that arrives as late as TMO_CYCLES cycles after the strobe cycle is still accepted.
- R7: If no acknowledge arrives within TMO_CYCLES cycles after a strobe, the command aborts with no further access. The result is 3'b011 and `err_o` is 1.
- R8: A start while the engine is busy is ignored. It changes neither the direction used nor the number of accesses.
- R9: `done_o` is a one-cycle pulse. `result_o` and `err_o` stay unchanged until the next completion. `err_o` is cleared when a new command starts.
- R10: After reset the engine is idle: `result_o` is 3'b011, `err_o`, `done_o`, `busy_o` and `bit_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch one triplet command while idle |
| dir_req_i | input | 1 | Preferred branch direction, sampled at start |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | {direction, complement bit, address bit}, or 3'b011 |
| err_o | output | 1 | Last command aborted on a missing acknowledge |
| bit_req_o | output | 1 | One-cycle request strobe to the bit port |
| bit_wr_o | output | 1 | Access kind with the strobe: 1 write, 0 read |
| bit_wdata_o | output | 1 | Bit to write with a write strobe |
| bit_ack_i | input | 1 | One-cycle access acknowledge |
| bit_rdata_i | input | 1 | Read bit, valid with the acknowledge |

## Verification
The bench drives all four address/complement pairs and both preferred directions. A design that swaps the two reads, ignores the forcing rule, or writes after an empty bus would return a wrong code or a wrong write value. An acknowledge that comes exactly at the timeout limit must still be accepted, so a counter off by one would abort a good access. A silent bus must produce the error code after one access. A second start while busy, together with a preferred direction that changes after start, shows whether the engine relaunches or samples the direction late. The pulse width of `done_o`, the hold of the result, and the clearing of the error flag by the following command are also checked.

// File: rtl/owtrip_pkg.sv
package owtrip_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE_ID,
      ST_WAIT_ID,
      ST_ISSUE_CMP,
      ST_WAIT_CMP,
      ST_ISSUE_WR,
      ST_WAIT_WR
   } trip_state_t;

   localparam logic [2:0] CODE_ABSENT = 3'b011;
endpackage

// File: rtl/owtrip_timer.sv
module owtrip_timer #(
   parameter int TMO_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting_i,
   output logic expired_o
);
   generate
      if (TMO_CYCLES == 0) begin : g_no_timer
         assign expired_o = 1'b0;
      end else begin : g_timer
         localparam int CW = $clog2(TMO_CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (!waiting_i) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
         end

         assign expired_o = waiting_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/owtrip_decide.sv
module owtrip_decide (
   input  logic id_i,
   input  logic cmp_i,
   input  logic dir_req_i,
   output logic absent_o,
   output logic dir_take_o
);
   always_comb begin
      absent_o   = id_i & cmp_i;
      dir_take_o = (id_i ^ cmp_i) ? id_i : dir_req_i;
   end
endmodule

// File: rtl/owsrch_triplet.sv
module owsrch_triplet
   import owtrip_pkg::*;
#(
   parameter int TMO_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       dir_req_i,
   output logic       busy_o,
   output logic       done_o,
   output logic [2:0] result_o,
   output logic       err_o,
   output logic       bit_req_o,
   output logic       bit_wr_o,
   output logic       bit_wdata_o,
   input  logic       bit_ack_i,
   input  logic       bit_rdata_i
);
   generate
      if (TMO_CYCLES == 1 || TMO_CYCLES < 0) begin : g_bad_tmo
         $error("TMO_CYCLES must be 0 (no timeout) or at least 2");
      end
   endgenerate

   trip_state_t state_q;
   logic        id_q, cmp_q, dir_q;
   logic        done_q, err_q;
   logic [2:0]  res_q;
   logic        waiting, expired, absent, dir_take;

   assign waiting = (state_q == ST_WAIT_ID) || (state_q == ST_WAIT_CMP) ||
                    (state_q == ST_WAIT_WR);

   owtrip_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .waiting_i(waiting),
      .expired_o(expired)
   );

   owtrip_decide u_decide (
      .id_i      (id_q),
      .cmp_i     (bit_rdata_i),
      .dir_req_i (dir_q),
      .absent_o  (absent),
      .dir_take_o(dir_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         id_q    <= 1'b0;
         cmp_q   <= 1'b0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         res_q   <= CODE_ABSENT;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               dir_q   <= dir_req_i;
               err_q   <= 1'b0;
               state_q <= ST_ISSUE_ID;
            end
            ST_ISSUE_ID:  state_q <= ST_WAIT_ID;
            ST_WAIT_ID: begin
               if (bit_ack_i) begin
                  id_q    <= bit_rdata_i;
                  state_q <= ST_ISSUE_CMP;
               end else if (expired) begin
                  res_q   <= CODE_ABSENT;
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_ISSUE_CMP: state_q <= ST_WAIT_CMP;
            ST_WAIT_CMP: begin
               if (bit_ack_i) begin
                  cmp_q <= bit_rdata_i;
                  if (absent) begin
                     res_q   <= CODE_ABSENT;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     dir_q   <= dir_take;
                     state_q <= ST_ISSUE_WR;
                  end
               end else if (expired) begin
                  res_q   <= CODE_ABSENT;
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_ISSUE_WR:  state_q <= ST_WAIT_WR;
            ST_WAIT_WR: begin
               if (bit_ack_i) begin
                  res_q   <= {dir_q, cmp_q, id_q};
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (expired) begin
                  res_q   <= CODE_ABSENT;
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign result_o    = res_q;
   assign err_o       = err_q;
   assign bit_req_o   = (state_q == ST_ISSUE_ID) || (state_q == ST_ISSUE_CMP) ||
                        (state_q == ST_ISSUE_WR);
   assign bit_wr_o    = (state_q == ST_ISSUE_WR);
   assign bit_wdata_o = (state_q == ST_ISSUE_WR) && dir_q;
endmodule

// File: rtl/owtrip_chk.sv
module owtrip_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       busy_o,
   input logic       done_o,
   input logic [2:0] result_o,
   input logic       err_o,
   input logic       bit_req_o,
   input logic       bit_wr_o,
   input logic       bit_wdata_o,
   input logic       bit_ack_i,
   input logic       bit_rdata_i
);
   logic       pend_q, pend_wr_q;
   logic [1:0] rd_n_q;
   logic       id_s_q, cmp_s_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_wr_q <= 1'b0;
         rd_n_q    <= 2'd0;
         id_s_q    <= 1'b0;
         cmp_s_q   <= 1'b0;
      end else begin
         if (done_o)
            pend_q <= 1'b0;
         else if (bit_req_o) begin
            pend_q    <= 1'b1;
            pend_wr_q <= bit_wr_o;
         end else if (bit_ack_i && pend_q)
            pend_q <= 1'b0;

         if (start_i && !busy_o)
            rd_n_q <= 2'd0;
         else if (bit_ack_i && pend_q && !pend_wr_q && rd_n_q != 2'd2) begin
            if (rd_n_q == 2'd0) id_s_q  <= bit_rdata_i;
            else                cmp_s_q <= bit_rdata_i;
            rd_n_q <= rd_n_q + 2'd1;
         end
      end
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req_o |-> !pend_q); // R6
   AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req_o && bit_wr_o) |-> (rd_n_q == 2'd2)); // R1
   AST_NO_WRITE_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req_o && bit_wr_o) |-> !(id_s_q && cmp_s_q)); // R2
   AST_FORCED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req_o && bit_wr_o && (id_s_q != cmp_s_q)) |-> (bit_wdata_o == id_s_q)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o)); // R9
   AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (result_o == 3'b011)); // R7
endmodule

bind owsrch_triplet owtrip_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o),
   .err_o      (err_o),
   .bit_req_o  (bit_req_o),
   .bit_wr_o   (bit_wr_o),
   .bit_wdata_o(bit_wdata_o),
   .bit_ack_i  (bit_ack_i),
   .bit_rdata_i(bit_rdata_i)
);

// File: tb/owsrch_triplet_bench.sv
`timescale 1ns/1ps
module owsrch_triplet_bench;
   localparam int TMO = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, dir_req_i = 1'b0;
   logic bit_ack_i = 1'b0, bit_rdata_i = 1'b0;
   logic busy_o, done_o, err_o, bit_req_o, bit_wr_o, bit_wdata_o;
   logic [2:0] result_o;

   int checks = 0, errors = 0;
   bit finished = 0;

   // bus model state
   logic m_id = 0, m_cmp = 0, m_mute = 0;
   int   m_dly = 1, m_nacc = 0, m_rdi = 0, m_cnt = 0;
   logic m_pend = 0, m_val = 0, m_wval = 0;
   logic m_kind [0:7];

   always #2 clk = ~clk;

   owsrch_triplet #(.TMO_CYCLES(TMO)) u_owsrch_triplet (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_req_i(dir_req_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o),
      .bit_req_o(bit_req_o), .bit_wr_o(bit_wr_o), .bit_wdata_o(bit_wdata_o),
      .bit_ack_i(bit_ack_i), .bit_rdata_i(bit_rdata_i)
   );

   initial begin
      forever begin
         @(negedge clk);
         bit_ack_i = 1'b0;
         if (m_pend) begin
            if (m_cnt <= 1) begin
               bit_ack_i   = 1'b1;
               bit_rdata_i = m_val;
               m_pend      = 1'b0;
            end else m_cnt = m_cnt - 1;
         end
         if (bit_req_o) begin
            if (m_nacc < 8) m_kind[m_nacc] = bit_wr_o;
            m_nacc = m_nacc + 1;
            if (bit_wr_o) m_wval = bit_wdata_o;
            else begin
               m_val = (m_rdi == 0) ? m_id : m_cmp;
               m_rdi = m_rdi + 1;
            end
            if (!m_mute) begin
               m_pend = 1'b1;
               m_cnt  = m_dly;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_trip(input logic id, input logic cmp, input logic dir,
                           input int dly, input bit mute, input bit poke,
                           input logic [2:0] exp_res, input logic exp_err,
                           input int exp_acc, input logic exp_wval, input string tag);
      int n;
      logic [2:0] held;
      m_id = id; m_cmp = cmp; m_dly = dly; m_mute = mute;
      m_nacc = 0; m_rdi = 0; m_wval = 1'bx;
      @(negedge clk);
      start_i = 1'b1; dir_req_i = dir;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         start_i   = poke && (n == 3);
         dir_req_i = ~dir;
      end while (!done_o && n < 400);
      start_i = 1'b0;
      chk(done_o == 1'b1, {tag, " R9 done seen"}, done_o, 1);
      chk(result_o == exp_res, {tag, " R5 result"}, result_o, exp_res);
      chk(err_o == exp_err, {tag, " R7 err"}, err_o, exp_err);
      chk(m_nacc == exp_acc, {tag, " R1 access count"}, m_nacc, exp_acc);
      if (exp_acc >= 2)
         chk(m_kind[0] == 1'b0 && m_kind[1] == 1'b0, {tag, " R1 two reads first"},
             {m_kind[0], m_kind[1]}, 0);
      if (exp_acc == 3) begin
         chk(m_kind[2] == 1'b1, {tag, " R1 write third"}, m_kind[2], 1);
         chk(m_wval == exp_wval, {tag, " write value"}, m_wval, exp_wval);
      end
      held = result_o;
      @(negedge clk);
      chk(done_o == 1'b0, {tag, " R9 done one cycle"}, done_o, 0);
      repeat (3) @(negedge clk);
      chk(result_o == held && busy_o == 1'b0 && m_nacc == exp_acc,
          {tag, " R9 result held, R8 no relaunch"}, result_o, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(result_o == 3'b011, "R10 reset result", result_o, 3);
      chk(!err_o && !done_o && !busy_o && !bit_req_o, "R10 reset flags",
          {err_o, done_o, busy_o, bit_req_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(result_o == 3'b011 && !busy_o, "R10 idle after release", result_o, 3);

      run_trip(0, 0, 0, 1, 0, 0, 3'b000, 0, 3, 0, "R3 both zero dir0");
      run_trip(0, 0, 1, 2, 0, 0, 3'b100, 0, 3, 1, "R3 both zero dir1");
      run_trip(1, 0, 0, 1, 0, 0, 3'b101, 0, 3, 1, "R4 id only dir0");
      run_trip(0, 1, 1, 3, 0, 0, 3'b010, 0, 3, 0, "R4 cmp only dir1");
      run_trip(1, 1, 1, 1, 0, 0, 3'b011, 0, 2, 0, "R2 no slave");
      run_trip(1, 0, 1, TMO, 0, 0, 3'b101, 0, 3, 1, "R6 ack at limit");
      run_trip(0, 0, 1, 2, 0, 1, 3'b100, 0, 3, 1, "R8 start while busy");
      run_trip(0, 0, 0, 1, 1, 0, 3'b011, 1, 1, 0, "R7 silent bus");
      m_pend = 0;
      run_trip(0, 0, 1, 1, 0, 0, 3'b100, 0, 3, 1, "R9 err cleared by restart");
      run_trip(1, 1, 0, 2, 0, 0, 3'b011, 0, 2, 0, "R2 no slave dir0");

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule